// File: doc/BRIEF.md
# Register-bank stack sequencer

This block moves register contents between a bank of eight 16-bit general registers and a byte-addressed stack held in a single-port, word-wide memory. It runs four commands. Two move one register: a push of one register and a pop into one register. Two move the whole bank: a save of all eight registers and a restore of all eight. The register bank, the stack pointer register and the memory all sit outside the block. The sequencer drives the memory address and strobes, reads the bank through one read port, writes the bank through one write port, and updates the stack pointer through its own write port.

A command is taken only while the block is idle. Each push beat writes one word to memory in one cycle. Pops are pipelined: the read of word k+1 is issued in the same cycle that word k, returned one cycle after its read, is written into the bank. The stack pointer moves in steps of 2 and wraps modulo 2^16. The block pulses a completion flag for one cycle when the last transfer of a command finishes.

Top module: `regstk_seq`

## Requirements
- R1: While reset is held and at the first sample after it is released, `busy_o`, `done_o`, `mem_we_o`, `mem_re_o`, `rf_we_o` and `sp_we_o` are all 0.
- R2: Op code 00 (push one) writes the named register's value to the word at byte address SP-2, leaves SP at SP-2, and raises `done_o` in the first cycle after the accepting edge. `mem_addr_o` is the byte address of the word's low byte, so the low data byte lands at the lower address.
- R3: Op code 10 (push all) writes register indices 0 to 7 in turn, with index i at SP-2(i+1). Indices 0 to 7 stand for the accumulator, count, data, base, stack pointer, base pointer, source index and destination index. The command ends with SP lowered by 16 after 8 write cycles, and `done_o` rises in the 8th cycle.
- R4: Whenever the stack-pointer index (4) is pushed, by op 00 or op 10, the stored word is the SP value held before the command was accepted.
- R5: Op code 01 (pop one) reads the word at SP into the named register and leaves SP at SP+2. Read data is expected on `mem_rdata_i` one cycle after `mem_re_o`, and `done_o` rises in the 2nd cycle after acceptance.
- R6: A pop-one into index 4 loads SP with the popped word and does not apply the +2 step.
- R7: Op code 11 (pop all) restores indices 7 down to 0. Index 7 comes from SP and index 0 from SP+14. The word in the stack-pointer slot is read and thrown away, so index 4 is never written and SP is not loaded from it. The command ends with SP raised by 16, and `done_o` rises in the 9th cycle.
- R8: Every stack address and SP update wraps modulo 2^16. For example, a push below 0000H goes to FFFEH, and a restore crossing FFFEH continues at 0000H.
- R9: `done_o` lasts exactly one cycle. `busy_o` is high from the cycle after acceptance through the done cycle. Commands presented while busy are ignored and cause no memory access.
- R10: During pop all, a read is issued every cycle for 8 cycles. Each bank write follows the read issued one cycle earlier, so writeback and the next read share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present; taken when idle |
| cmd_op_i | input | 2 | 00 push one, 01 pop one, 10 push all, 11 pop all |
| cmd_reg_i | input | 3 | Register index for the single-register forms |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse on the last transfer |
| rf_raddr_o | output | 3 | Register bank read index |
| rf_rdata_i | input | 16 | Register bank read data (combinational) |
| rf_we_o | output | 1 | Register bank write enable |
| rf_waddr_o | output | 3 | Register bank write index |
| rf_wdata_o | output | 16 | Register bank write data |
| sp_i | input | 16 | Current stack pointer, sampled at acceptance |
| sp_we_o | output | 1 | Stack pointer write enable |
| sp_wdata_o | output | 16 | New stack pointer value |
| mem_addr_o | output | 16 | Byte address of the word's low byte |
| mem_we_o | output | 1 | Memory word write |
| mem_re_o | output | 1 | Memory word read, data one cycle later |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |

## Verification
In pop all, the bank write of one popped word falls in the same cycle as the read of the next word. Both also share that cycle with a stack-pointer step. The bench restores the bank from eight distinct preloaded words and counts the cycles in which `rf_we_o` and `mem_re_o` are both high. It expects six such cycles, because the discarded stack-pointer slot removes one overlap. It then compares every restored register with the word expected at its address. A pop into the stack-pointer index is also run, where the writeback cycle follows the pointer step; the bench judges it by the final SP value.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH1 = 2'd0,
    OP_POP1  = 2'd1,
    OP_PUSHA = 2'd2,
    OP_POPA  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_RD   = 2'd2,
    ST_WB   = 2'd3
  } stk_st_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  stk_op_e          cmd_op_i,
  input  logic [IDX_W-1:0] cmd_reg_i,
  output stk_st_e          st_o,
  output logic             all_o,
  output logic             last_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] tgt_o
);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(NUM_REGS - 1);

  stk_st_e          st_q;
  stk_op_e          op_q;
  logic [IDX_W-1:0] reg_q;
  logic [IDX_W-1:0] beat_q;
  logic             is_push;

  assign accept_o = (st_q == ST_IDLE) && cmd_valid_i;
  assign all_o    = (op_q == OP_PUSHA) || (op_q == OP_POPA);
  assign is_push  = (op_q == OP_PUSH1) || (op_q == OP_PUSHA);
  assign last_o   = !all_o || (beat_q == LAST_BEAT);
  assign st_o     = st_q;

  // save walks up the index list, restore walks down
  always_comb begin
    if (!all_o)       tgt_o = reg_q;
    else if (is_push) tgt_o = beat_q;
    else              tgt_o = LAST_BEAT - beat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PUSH1;
      reg_q  <= '0;
      beat_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_o) begin
          op_q   <= cmd_op_i;
          reg_q  <= cmd_reg_i;
          beat_q <= '0;
          st_q   <= (cmd_op_i == OP_PUSH1 || cmd_op_i == OP_PUSHA) ? ST_PUSH : ST_RD;
        end
        ST_PUSH: begin
          if (last_o) st_q <= ST_IDLE;
          else        beat_q <= beat_q + 1'b1;
        end
        ST_RD: begin
          if (last_o) st_q <= ST_WB;
          else        beat_q <= beat_q + 1'b1;
        end
        ST_WB:   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int ADDR_W = 16,
  parameter int STEP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              dec_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] dec_val_o,
  output logic [ADDR_W-1:0] inc_val_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] ptr_q, base_q;

  // modular arithmetic gives the cyclic stack region
  assign dec_val_o = ptr_q - STEP_V;
  assign inc_val_o = ptr_q + STEP_V;
  assign ptr_o     = ptr_q;
  assign base_o    = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (load_i) begin
      ptr_q  <= load_val_i;
      base_q <= load_val_i;
    end else if (dec_i) begin
      ptr_q  <= dec_val_o;
    end else if (inc_i) begin
      ptr_q  <= inc_val_o;
    end
  end
endmodule

// File: rtl/stk_wb.sv
module stk_wb #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int SP_IDX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  tgt_i,
  input  logic              all_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              sp_load_o
);
  logic             vld_q, all_q, hit_sp;
  logic [IDX_W-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      all_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      vld_q <= issue_i;
      if (issue_i) begin
        all_q <= all_i;
        tgt_q <= tgt_i;
      end
    end
  end

  // SP slot never reaches the bank; full restore drops it entirely
  assign hit_sp     = vld_q && (tgt_q == IDX_W'(SP_IDX));
  assign rf_we_o    = vld_q && !hit_sp;
  assign sp_load_o  = hit_sp && !all_q;
  assign rf_waddr_o = tgt_q;
  assign rf_wdata_o = mem_rdata_i;
endmodule

// File: rtl/regstk_seq.sv
module regstk_seq
  import stk_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int SP_IDX   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [IDX_W-1:0]  cmd_reg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              sp_we_o,
  output logic [ADDR_W-1:0] sp_wdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int STEP = DATA_W / 8;

  stk_st_e           st;
  logic              all, last, accept, in_push, in_rd, sp_load;
  logic [IDX_W-1:0]  tgt;
  logic [ADDR_W-1:0] ptr, ptr_dec, ptr_inc, base;

  stk_ctrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (stk_op_e'(cmd_op_i)),
    .cmd_reg_i  (cmd_reg_i),
    .st_o       (st),
    .all_o      (all),
    .last_o     (last),
    .accept_o   (accept),
    .tgt_o      (tgt)
  );

  assign in_push = (st == ST_PUSH);
  assign in_rd   = (st == ST_RD);

  stk_ptr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(sp_i),
    .dec_i     (in_push),
    .inc_i     (in_rd),
    .ptr_o     (ptr),
    .dec_val_o (ptr_dec),
    .inc_val_o (ptr_inc),
    .base_o    (base)
  );

  stk_wb #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SP_IDX(SP_IDX)) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (in_rd),
    .tgt_i      (tgt),
    .all_i      (all),
    .mem_rdata_i(mem_rdata_i),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .sp_load_o  (sp_load)
  );

  assign busy_o     = (st != ST_IDLE);
  assign done_o     = (in_push && last) || (st == ST_WB);
  assign rf_raddr_o = tgt;

  // pre-decrement on push, post-increment on pop
  assign mem_addr_o  = in_push ? ptr_dec : ptr;
  assign mem_we_o    = in_push;
  assign mem_re_o    = in_rd;
  // SP slot stores the value held at acceptance
  assign mem_wdata_o = (tgt == IDX_W'(SP_IDX)) ? DATA_W'(base) : rf_rdata_i;

  // sp_load only occurs in ST_WB, never alongside a pointer step
  assign sp_we_o    = in_push || in_rd || sp_load;
  assign sp_wdata_o = sp_load ? ADDR_W'(mem_rdata_i) : (in_push ? ptr_dec : ptr_inc);
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int SP_IDX = 4,
  parameter int STEP   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              sp_we_o,
  input logic [ADDR_W-1:0] sp_wdata_o,
  input logic              rf_we_o,
  input logic [IDX_W-1:0]  rf_waddr_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_we_o || mem_re_o || rf_we_o || sp_we_o || done_o));

  // R9
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  // R2
  push_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (sp_we_o && sp_wdata_o == mem_addr_o));

  // R3
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - STEP_V));

  // R5
  pop_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (sp_we_o && sp_wdata_o == mem_addr_o + STEP_V));

  // R7
  no_sp_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_waddr_o != IDX_W'(SP_IDX)));

  // R10
  wb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $past(mem_re_o));
endmodule

bind regstk_seq stk_seq_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SP_IDX(SP_IDX), .STEP(DATA_W / 8)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mem_we_o  (mem_we_o),
  .mem_re_o  (mem_re_o),
  .mem_addr_o(mem_addr_o),
  .sp_we_o   (sp_we_o),
  .sp_wdata_o(sp_wdata_o),
  .rf_we_o   (rf_we_o),
  .rf_waddr_o(rf_waddr_o)
);

// File: tb/sim_regstk_seq.sv
module sim_regstk_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_reg;
  logic        busy, done;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we, sp_we, mem_we, mem_re;
  logic [15:0] sp_m, sp_wdata, mem_addr, mem_wdata, rd_q;

  regstk_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_reg_i(cmd_reg), .busy_o(busy), .done_o(done), .rf_raddr_o(rf_raddr),
    .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wdata_o(rf_wdata), .sp_i(sp_m), .sp_we_o(sp_we), .sp_wdata_o(sp_wdata),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rd_q)
  );

  logic [7:0]  mem_m [int unsigned];
  logic [15:0] rf_m [8];

  // preload channel, applied by the model process only
  logic        ld_go;
  logic [15:0] ld_seed, ld_sp;
  logic        pk_we;
  logic [15:0] pk_a, pk_d;

  int n_chk = 0, n_fail = 0;
  int lat, ovl, n_re, n_we;
  bit finished = 0;

  function automatic logic [15:0] rfv(input logic [15:0] seed, input int i);
    return seed ^ (16'(i) * 16'h1111);
  endfunction

  function automatic logic [7:0] rdb(input logic [15:0] a);
    if (mem_m.exists(32'(a))) return mem_m[32'(a)];
    return 8'h00;
  endfunction

  function automatic logic [15:0] word_at(input logic [15:0] a);
    return {rdb(16'(a + 16'd1)), rdb(a)};
  endfunction

  assign rf_rdata = rf_m[rf_raddr];

  always @(posedge clk) begin
    if (ld_go) begin
      for (int i = 0; i < 8; i++) rf_m[i] <= rfv(ld_seed, i);
      sp_m <= ld_sp;
    end
    if (pk_we) begin
      mem_m[32'(pk_a)] = pk_d[7:0];
      mem_m[32'(16'(pk_a + 16'd1))] = pk_d[15:8];
    end
    if (mem_re) rd_q <= word_at(mem_addr);
    if (mem_we) begin
      mem_m[32'(mem_addr)] = mem_wdata[7:0];
      mem_m[32'(16'(mem_addr + 16'd1))] = mem_wdata[15:8];
    end
    if (rf_we) rf_m[rf_waddr] <= rf_wdata;
    if (sp_we) sp_m <= sp_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic preset(input logic [15:0] seed, input logic [15:0] sp0);
    @(negedge clk); ld_seed = seed; ld_sp = sp0; ld_go = 1'b1;
    @(negedge clk); ld_go = 1'b0;
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); pk_a = a; pk_d = d; pk_we = 1'b1;
    @(negedge clk); pk_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [2:0] r, input bit noise);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_reg = r;
    @(negedge clk);
    chk("R9", busy, 1, "busy after accept");
    if (noise) cmd_op = 2'd1; else cmd_valid = 1'b0;
    lat = 1; ovl = 0; n_re = 0; n_we = 0;
    while (1) begin
      if (mem_re) n_re++;
      if (mem_we) n_we++;
      if (rf_we && mem_re) ovl++;
      if (done || lat > 40) break;
      @(negedge clk); lat++;
    end
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R9", done, 0, "done single cycle");
    chk("R9", busy, 0, "idle after done");
    chk("R9", {mem_we, mem_re}, 0, "no access after done");
  endtask

  task automatic t_reset();
    chk("R1", {busy, done, mem_we, mem_re, rf_we, sp_we}, 0, "reset outputs");
  endtask

  task automatic t_push_one();
    preset(16'h0A0B, 16'h0100);
    run_cmd(2'd0, 3'd2, 0);
    chk("R2", lat, 1, "push one latency");
    chk("R2", word_at(16'h00FE), rfv(16'h0A0B, 2), "pushed word");
    chk("R2", rdb(16'h00FE), 8'(rfv(16'h0A0B, 2)), "low byte at low address");
    chk("R2", sp_m, 16'h00FE, "sp after push");
  endtask

  task automatic t_push_sp();
    preset(16'h1234, 16'h0200);
    run_cmd(2'd0, 3'd4, 0);
    chk("R4", word_at(16'h01FE), 16'h0200, "pushed sp is pre-command value");
    chk("R2", sp_m, 16'h01FE, "sp after push sp");
  endtask

  task automatic t_push_all();
    preset(16'h5A00, 16'h1000);
    run_cmd(2'd2, 3'd0, 0);
    chk("R3", lat, 8, "push all latency");
    chk("R3", n_we, 8, "push all write count");
    for (int i = 0; i < 8; i++) begin
      if (i == 4) chk("R4", word_at(16'(16'h1000 - 2 * (i + 1))), 16'h1000, "sp slot");
      else        chk("R3", word_at(16'(16'h1000 - 2 * (i + 1))), rfv(16'h5A00, i), "slot order");
    end
    chk("R3", sp_m, 16'h0FF0, "sp after push all");
  endtask

  task automatic t_pop_one();
    poke(16'h0300, 16'hBEEF);
    preset(16'h2222, 16'h0300);
    run_cmd(2'd1, 3'd6, 0);
    chk("R5", lat, 2, "pop one latency");
    chk("R5", rf_m[6], 16'hBEEF, "popped value");
    chk("R5", rf_m[5], rfv(16'h2222, 5), "neighbour untouched");
    chk("R5", sp_m, 16'h0302, "sp after pop");
  endtask

  task automatic t_pop_sp();
    poke(16'h0400, 16'h5A5A);
    preset(16'h3333, 16'h0400);
    run_cmd(2'd1, 3'd4, 0);
    chk("R6", sp_m, 16'h5A5A, "sp loaded from popped word");
  endtask

  task automatic t_pop_all();
    for (int k = 0; k < 8; k++) poke(16'(16'h2000 + 2 * k), 16'(16'hC000 + k));
    preset(16'h7070, 16'h2000);
    run_cmd(2'd3, 3'd0, 0);
    chk("R7", lat, 9, "pop all latency");
    chk("R10", n_re, 8, "read beats");
    chk("R10", ovl, 6, "writeback overlaps next read");
    for (int k = 0; k < 8; k++) begin
      if (k != 3) chk("R7", rf_m[7 - k], 16'(16'hC000 + k), "restore order");
    end
    chk("R7", rf_m[4], rfv(16'h7070, 4), "sp slot discarded");
    chk("R7", sp_m, 16'h2010, "sp after pop all");
  endtask

  task automatic t_wrap();
    preset(16'h9C00, 16'h0004);
    run_cmd(2'd2, 3'd0, 0);
    chk("R8", word_at(16'h0002), rfv(16'h9C00, 0), "first slot");
    chk("R8", word_at(16'hFFFE), rfv(16'h9C00, 2), "wrapped slot");
    chk("R8", word_at(16'hFFF4), rfv(16'h9C00, 7), "last slot");
    chk("R8", sp_m, 16'hFFF4, "sp wrapped");
    preset(16'h0000, 16'hFFF4);
    run_cmd(2'd3, 3'd0, 0);
    for (int i = 0; i < 8; i++) begin
      if (i != 4) chk("R8", rf_m[i], rfv(16'h9C00, i), "round trip across wrap");
    end
    chk("R8", sp_m, 16'h0004, "sp after wrapped restore");
  endtask

  task automatic t_busy_ignore();
    preset(16'h4141, 16'h3000);
    run_cmd(2'd2, 3'd0, 1);
    chk("R9", lat, 8, "latency with pending command");
    chk("R9", n_re, 0, "no read from ignored pop");
    chk("R9", sp_m, 16'h2FF0, "sp unaffected");
    chk("R9", word_at(16'h2FFE), rfv(16'h4141, 0), "save intact");
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_reg = '0;
    ld_go = 1'b0; ld_seed = '0; ld_sp = '0; pk_we = 1'b0; pk_a = '0; pk_d = '0;
    sp_m = '0; rd_q = '0;
    for (int i = 0; i < 8; i++) rf_m[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", {busy, done, mem_we, mem_re, rf_we, sp_we}, 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_one();
    t_push_sp();
    t_push_all();
    t_pop_one();
    t_pop_sp();
    t_pop_all();
    t_wrap();
    t_busy_ignore();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule